// File: doc/BRIEF.md
# Memory Parity Error Checker

This block sits on the path between a processor and a 16-bit word memory. The memory keeps one extra bit for each word, and this block owns that bit. On a store it computes the bit so that the 17 stored bits hold an odd number of ones. On a load it checks the word against the stored bit. Detection has to be armed first. A bad load inside installed memory then latches a pending parity error and records the word address in a violation register, with the top bit set as a marker. The error reaches the processor as an interrupt only while a separate control enable is high.

Detection works once per arming. When the processor acknowledges the interrupt, the pending error clears and detection is disarmed, so software must arm it again before the next error can be seen. While the error is being delivered, two things follow. Lower-priority I/O interrupts are held off. Memory-protect violations are masked, both the one that arrives in the cycle the error is found and any that arrive while the error stays pending. A test-mode input inverts the check so that a good word reads as bad. This lets a self-test walk memory and expect an interrupt at every address it reads. Loads above the installed size are ignored. The installed size is counted in 4K-word blocks.

Top module: `parity_guard`

## Requirements
- R1: `wr_par` always equals the inverse of the XOR of `wr_data`, which is odd parity over 17 bits. A store never latches an error, whatever the other inputs are.
- R2: `arm_set` arms detection and `arm_clr` disarms it; `arm_clr` wins when both are high. While detection is disarmed, a bad load latches nothing and raises no interrupt.
- R3: A load counts as bad when the XOR of `rd_data` and `rd_par` is 0. An armed, in-range bad load with `ctl_en` high raises `irq` on the next clock.
- R4: While `ctl_en` is low, a bad load latches no error and `irq` stays low.
- R5: When `irq_ack` is high during `irq`, `irq` is low on the next clock and detection is disarmed. A later bad load raises nothing until the next `arm_set`.
- R6: A load counts as in range only when `acc_addr[14:12]` is below `mem_blocks`. Loads outside that range never flag an error.
- R7: When an error is latched, `viol` takes the value {1'b1, acc_addr}. It keeps this first value while the error is pending, and keeps it after the acknowledge.
- R8: `mpv_pass` passes `mpv_req` through, but it is forced low while `irq` is high and in the cycle when an error is being detected.
- R9: `io_hold` is high exactly while `irq` is high.
- R10: While `test_mode` is high, a good-parity load in range counts as bad. Walking addresses from 0 in steps of 1 up to octal 1777, then in steps of octal 1000 to the top of a 32K-word space, raises an interrupt at every address.
- R11: Reset clears the armed state, the pending error and `viol`.
- R12: A load with good parity, with `test_mode` low, raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low system preset |
| acc_valid | input | 1 | A memory access takes place this cycle |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_addr | input | 15 | Word address of the access |
| wr_data | input | 16 | Store data |
| wr_par | output | 1 | Parity bit to store with `wr_data` |
| rd_data | input | 16 | Load data returned from memory |
| rd_par | input | 1 | Stored parity bit returned with `rd_data` |
| arm_set | input | 1 | Arms detection |
| arm_clr | input | 1 | Disarms detection |
| ctl_en | input | 1 | Interrupt control enable |
| test_mode | input | 1 | Forces loads to be judged bad |
| mem_blocks | input | 4 | Installed memory in 4K-word blocks (0 to 8) |
| irq_ack | input | 1 | Interrupt acknowledge |
| mpv_req | input | 1 | Memory-protect violation request |
| irq | output | 1 | Parity-error interrupt request |
| io_hold | output | 1 | Holds off lower-priority I/O interrupts |
| mpv_pass | output | 1 | Memory-protect violation after priority masking |
| viol | output | 16 | Violation register: marker bit and failing address |

## Verification
The hardest case to reach is a second bad load that arrives after the acknowledge, because the one-shot disarm is otherwise invisible at the ports. The bench takes an interrupt, acknowledges it, and then issues another bad load without arming again. It checks that nothing fires, and that the same load fires once detection is re-armed. Memory-protect priority in the detecting cycle is checked combinationally, before the clock edge. The test-mode walk covers the two-rate address sequence up to the top of the address space.

// File: rtl/parity_guard.sv
module parity_guard #(
  parameter int DW    = 16,
  parameter int AW    = 15,
  parameter int BLK_W = 12,
  localparam int NB   = AW - BLK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc_valid,
  input  logic          acc_write,
  input  logic [AW-1:0] acc_addr,
  input  logic [DW-1:0] wr_data,
  output logic          wr_par,
  input  logic [DW-1:0] rd_data,
  input  logic          rd_par,
  input  logic          arm_set,
  input  logic          arm_clr,
  input  logic          ctl_en,
  input  logic          test_mode,
  input  logic [NB:0]   mem_blocks,
  input  logic          irq_ack,
  input  logic          mpv_req,
  output logic          irq,
  output logic          io_hold,
  output logic          mpv_pass,
  output logic [AW:0]   viol
);

  logic armed, pend;
  logic in_range, rd_bad, err_now, take;

  assign wr_par   = ~^wr_data;
  assign in_range = {1'b0, acc_addr[AW-1:BLK_W]} < mem_blocks;
  assign rd_bad   = (~^{rd_data, rd_par}) ^ test_mode;
  assign err_now  = acc_valid & ~acc_write & in_range & rd_bad & armed & ctl_en & ~pend;
  assign irq      = pend & ctl_en;
  assign take     = irq & irq_ack;
  assign io_hold  = irq;
  assign mpv_pass = mpv_req & ~irq & ~err_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      pend  <= 1'b0;
      viol  <= '0;
    end else begin
      if (arm_clr)      armed <= 1'b0;
      else if (arm_set) armed <= 1'b1;
      if (take) begin
        pend  <= 1'b0;
        armed <= 1'b0;
      end else if (err_now) begin
        pend <= 1'b1;
        viol <= {1'b1, acc_addr};
      end
    end
  end

endmodule

// File: rtl/parity_guard_chk.sv
module parity_guard_chk #(
  parameter int AW    = 15,
  parameter int BLK_W = 12,
  localparam int NB   = AW - BLK_W
) (
  input logic          clk,
  input logic          rst_n,
  input logic          acc_valid,
  input logic          acc_write,
  input logic [AW-1:0] acc_addr,
  input logic [NB:0]   mem_blocks,
  input logic          ctl_en,
  input logic          irq_ack,
  input logic          irq,
  input logic          mpv_pass,
  input logic [AW:0]   viol,
  input logic          armed,
  input logic          pend
);

  assert_store_clean_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write && !pend) |=> !pend);

  assert_disarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !pend) |=> !pend);

  assert_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_en && !pend) |=> !pend);

  assert_ack_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && irq_ack) |=> (!irq && !armed));

  assert_out_of_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !acc_write && !pend && ({1'b0, acc_addr[AW-1:BLK_W]} >= mem_blocks)) |=> !pend);

  assert_viol_mark_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> viol[AW]);

  assert_viol_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && $past(pend)) |-> $stable(viol));

  assert_mpv_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> !mpv_pass);

endmodule

bind parity_guard parity_guard_chk #(.AW(AW), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_addr(acc_addr), .mem_blocks(mem_blocks), .ctl_en(ctl_en),
  .irq_ack(irq_ack), .irq(irq), .mpv_pass(mpv_pass), .viol(viol),
  .armed(armed), .pend(pend)
);

// File: tb/parity_guard_bench.sv
module parity_guard_bench;
  logic        clk = 0, rst_n = 0;
  logic        acc_valid = 0, acc_write = 0;
  logic [14:0] acc_addr = '0;
  logic [15:0] wr_data = '0, rd_data = '0;
  logic        rd_par = 0, arm_set = 0, arm_clr = 0, ctl_en = 1, test_mode = 0;
  logic [3:0]  mem_blocks = 4'd4;
  logic        irq_ack = 0, mpv_req = 0;
  logic        wr_par, irq, io_hold, mpv_pass;
  logic [15:0] viol;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  parity_guard u_parity_guard (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .wr_data(wr_data), .wr_par(wr_par), .rd_data(rd_data),
    .rd_par(rd_par), .arm_set(arm_set), .arm_clr(arm_clr), .ctl_en(ctl_en),
    .test_mode(test_mode), .mem_blocks(mem_blocks), .irq_ack(irq_ack),
    .mpv_req(mpv_req), .irq(irq), .io_hold(io_hold), .mpv_pass(mpv_pass), .viol(viol)
  );

  // {addr, data, par, test_mode, expect_irq}
  localparam logic [33:0] VEC [10] = '{
    {15'h0005, 16'h0000, 1'b1, 1'b0, 1'b0},
    {15'h0005, 16'h0000, 1'b0, 1'b0, 1'b1},
    {15'h3FFF, 16'h0001, 1'b0, 1'b0, 1'b0},
    {15'h3FFF, 16'h0001, 1'b1, 1'b0, 1'b1},
    {15'h4000, 16'h0000, 1'b0, 1'b0, 1'b0},
    {15'h7FFF, 16'h0000, 1'b0, 1'b0, 1'b0},
    {15'h03FF, 16'h1234, 1'b0, 1'b1, 1'b1},
    {15'h0200, 16'hFFFF, 1'b1, 1'b0, 1'b0},
    {15'h0200, 16'hFFFF, 1'b0, 1'b0, 1'b1},
    {15'h5000, 16'h0000, 1'b1, 1'b1, 1'b0}
  };

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [14:0] a, input logic [15:0] d, input logic p);
    @(negedge clk);
    acc_valid = 1; acc_write = 0; acc_addr = a; rd_data = d; rd_par = p;
    @(negedge clk);
    acc_valid = 0;
  endtask

  task automatic arm;
    @(negedge clk); arm_set = 1;
    @(negedge clk); arm_set = 0;
  endtask

  task automatic ack;
    @(negedge clk); irq_ack = 1;
    @(negedge clk); irq_ack = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1-chain timeout actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    // R11 reset state
    chk("R11 irq at reset", {15'd0, irq}, 16'd0);
    chk("R11 viol at reset", viol, 16'd0);
    rst_n = 1;
    @(negedge clk);

    // R12 R3 R6 R10 vector table
    for (int i = 0; i < 10; i++) begin
      test_mode = VEC[i][1];
      arm();
      rd(VEC[i][33:19], VEC[i][18:3], VEC[i][2]);
      chk($sformatf("R3 R12 R6 vec%0d irq", i), {15'd0, irq}, {15'd0, VEC[i][0]});
      if (VEC[i][0]) begin
        chk($sformatf("R7 vec%0d viol", i), viol, {1'b1, VEC[i][33:19]});
        chk($sformatf("R9 vec%0d io_hold", i), {15'd0, io_hold}, 16'd1);
        ack();
        chk($sformatf("R5 vec%0d irq after ack", i), {15'd0, irq}, 16'd0);
      end else begin
        arm_clr = 1; @(negedge clk); arm_clr = 0;
      end
      test_mode = 0;
    end

    // R1 store parity and no error from stores
    arm();
    @(negedge clk); acc_valid = 1; acc_write = 1; acc_addr = 15'h10; wr_data = 16'h0000;
    #1 chk("R1 wr_par 0000", {15'd0, wr_par}, 16'd1);
    wr_data = 16'h0007; #1 chk("R1 wr_par 0007", {15'd0, wr_par}, 16'd0);
    test_mode = 1; rd_data = 16'h0; rd_par = 0;
    @(negedge clk); acc_valid = 0; acc_write = 0; test_mode = 0;
    chk("R1 store flags nothing", {15'd0, irq}, 16'd0);

    // R2 disarm wins, disarmed bad load ignored
    @(negedge clk); arm_set = 1; arm_clr = 1;
    @(negedge clk); arm_set = 0; arm_clr = 0;
    rd(15'h20, 16'h0, 1'b0);
    chk("R2 disarmed bad load", {15'd0, irq}, 16'd0);

    // R4 control enable low
    arm(); ctl_en = 0;
    rd(15'h21, 16'h0, 1'b0);
    chk("R4 ctl_en low irq", {15'd0, irq}, 16'd0);
    ctl_en = 1;
    @(negedge clk);
    chk("R4 no latched error revealed", {15'd0, irq}, 16'd0);

    // R5 one-shot: after ack, no re-fire until rearm; R7 first error held
    rd(15'h22, 16'h0, 1'b0);
    chk("R5 armed fire", {15'd0, irq}, 16'd1);
    rd(15'h23, 16'h0, 1'b0);
    chk("R7 first address kept", viol, {1'b1, 15'h22});
    ack();
    chk("R7 viol after ack", viol, {1'b1, 15'h22});
    rd(15'h24, 16'h0, 1'b0);
    chk("R5 no refire before rearm", {15'd0, irq}, 16'd0);
    arm();
    rd(15'h24, 16'h0, 1'b0);
    chk("R5 refire after rearm", {15'd0, irq}, 16'd1);
    chk("R7 new address", viol, {1'b1, 15'h24});

    // R8 precedence over memory protect
    @(negedge clk); mpv_req = 1; #1
    chk("R8 mpv masked while pending", {15'd0, mpv_pass}, 16'd0);
    ack();
    chk("R8 mpv passes when idle", {15'd0, mpv_pass}, 16'd1);
    chk("R9 io_hold idle", {15'd0, io_hold}, 16'd0);
    arm();
    @(negedge clk); acc_valid = 1; acc_addr = 15'h30; rd_data = 16'h0; rd_par = 0; #1
    chk("R8 mpv masked in detecting cycle", {15'd0, mpv_pass}, 16'd0);
    @(negedge clk); acc_valid = 0; mpv_req = 0;
    ack();

    // R10 test-mode walk over full space
    begin
      int miss = 0;
      int a = 0;
      mem_blocks = 4'd8; test_mode = 1;
      while (a < 32768) begin
        arm();
        rd(a[14:0], 16'h0, 1'b1);
        if (irq !== 1'b1 || viol !== {1'b1, a[14:0]}) miss++;
        ack();
        a = (a < 'o1777) ? a + 1 : a + 'o1000;
      end
      test_mode = 0;
      chk("R10 walk misses", miss[15:0], 16'd0);
    end

    // R11 reset mid-operation
    arm();
    rd(15'h40, 16'h0, 1'b0);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    chk("R11 irq cleared", {15'd0, irq}, 16'd0);
    chk("R11 viol cleared", viol, 16'd0);
    rst_n = 1;
    rd(15'h41, 16'h0, 1'b0);
    chk("R11 disarmed after reset", {15'd0, irq}, 16'd0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule